// File: doc/BRIEF.md
# Boot-Block Flash Command Controller

This block models the command logic of a 256K x 16 boot-block flash, with storage scaled down to a small on-chip register array. A host drives an asynchronous-style bus of chip select, write strobe and output enable. All pins are sampled into the system clock. A command byte is taken from the data lanes when the write strobe rises while chip select is low. Program and erase each take two bus writes. After either one, reads return the status word until the host writes the read-array command again. The busy phase is a counter that holds the ready bit low for a fixed number of clocks.

The array is divided into seven erase blocks. In units of 4K real words they are: a boot block of 2 units, two parameter blocks of 1 unit each, a main block of 12 units and three main blocks of 16 units each. Each unit holds 2^UNIT_LOG2 words. With TOP_BOOT set, the boot block occupies the highest addresses. Otherwise the map is mirrored and the boot block starts at word 0. The boot block is hardware protected. A program or erase aimed at it goes ahead only if the write-protect release pin is high or the reset pin sits at its super-voltage level. The high-voltage-valid input must hold from the confirm cycle until the operation ends. A power-down pin clears the status, returns the block to array reads, aborts any operation and disables the data outputs.

Top module: `bbf_cmd_ctrl`

## Requirements
- R1: After reset, and after any power-down pulse, the block is in array-read mode and status bits 5, 4 and 3 read 0.
- R2: Writing 20h and then D0h to any address in a block sets every word of that block to FFFFh. The other blocks are unchanged.
- R3: If the write that follows 20h carries any byte other than D0h, nothing is erased. Status bits 5 (erase error) and 4 (program error) are set and the block enters status mode.
- R4: Writing 10h or 40h and then an address with data programs that word to old AND data.
- R5: Once the second write of a program or erase is accepted, reads return the status byte in bits 7:0 (upper byte 00h) until FFh is written. Bit 7 (ready) reads 0 for BUSY_CYCLES clocks while the operation runs.
- R6: When both boot_wp_release and rst_hv_unlock are low, a program or erase of the boot block leaves it unchanged and sets status bits 5 and 4, with ready still 1. Either pin high lets the operation proceed. No other block depends on these pins.
- R7: If vpp_good is low at the confirm write, or drops at any time before the operation completes, the array is unchanged. Status bit 3 (VPP low) is set, together with bit 5 for an erase or bit 4 for a program.
- R8: While pwr_down_n is low, every dq_oe bit is 0 and bus writes are ignored.
- R9: After 90h, reads with addr[0]=0 return 0089h. Reads with addr[0]=1 return 4470h when TOP_BOOT=1 and 4471h when TOP_BOOT=0.
- R10: With byte_mode_n low, only dq_oe[7:0] is set and data appears on dq_out[7:0]. dq_in[15] selects the byte: 1 picks bits 15:8 and 0 picks bits 7:0. A byte program ANDs dq_in[7:0] into the selected byte only.
- R11: Block membership follows the unit map given above, placed according to TOP_BOOT.
- R12: dq_oe is non-zero only when chip_sel_n is low, out_en_n is low and wr_strobe_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also loads the array with FFFFh |
| pwr_down_n | input | 1 | Power-down and reset pin, active low |
| rst_hv_unlock | input | 1 | High when the reset pin is at super-voltage; releases boot protection |
| boot_wp_release | input | 1 | Write-protect release for the boot block |
| vpp_good | input | 1 | Program/erase supply valid |
| chip_sel_n | input | 1 | Chip select, active low |
| wr_strobe_n | input | 1 | Write strobe, active low; a write is taken on its rising edge |
| out_en_n | input | 1 | Output enable, active low |
| byte_mode_n | input | 1 | Low selects 8-bit access |
| addr | input | 6+UNIT_LOG2 | Word address |
| dq_in | input | 16 | Data and command input; bit 15 is the byte select in byte mode |
| dq_out | output | 16 | Read data |
| dq_oe | output | 16 | Per-lane output enable (tri-state control) |

## Verification
The hardest case to reach from the ports is a supply drop in the middle of an operation. The confirm write must be accepted with vpp_good high, and vpp_good must then fall while the busy counter is still running. The stimulus lowers the pin a few clocks after the rising strobe and restores it before completion. It then checks the status byte and the untouched word. Both protection paths are also exercised against the same boot word. Before each path, a power-down pulse clears the sticky error bits.

// File: rtl/bbf_pkg.sv
package bbf_pkg;

    typedef enum logic [1:0] {RD_ARRAY, RD_IDENT, RD_STATUS} rd_mode_e;
    typedef enum logic [1:0] {ST_IDLE, ST_ERS_ARM, ST_PRG_ARM, ST_BUSY} cel_state_e;

    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_IDENT      = 8'h90;
    localparam logic [7:0] CMD_STATUS     = 8'h70;
    localparam logic [7:0] CMD_ERASE      = 8'h20;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_PROG_A     = 8'h10;
    localparam logic [7:0] CMD_PROG_B     = 8'h40;

    localparam logic [15:0] MFR_CODE = 16'h0089;
    localparam logic [15:0] DEV_TOP  = 16'h4470;
    localparam logic [15:0] DEV_BOT  = 16'h4471;

    // latched operation descriptor
    typedef struct packed {
        logic        erase;
        logic        byte_wr;
        logic        hi_byte;
        logic [15:0] data;
    } op_t;

    typedef struct packed {
        logic ready;
        logic ers_err;
        logic prg_err;
        logic vpp_low;
    } status_t;

    // 64 units; unit index -> erase block (0 = boot)
    function automatic logic [2:0] blk_of_unit(input logic [5:0] unit, input logic top_boot);
        logic [5:0] u;
        u = top_boot ? ~unit : unit;
        if (u < 6'd2)       return 3'd0;
        else if (u == 6'd2) return 3'd1;
        else if (u == 6'd3) return 3'd2;
        else if (u < 6'd16) return 3'd3;
        else if (u < 6'd32) return 3'd4;
        else if (u < 6'd48) return 3'd5;
        else                return 3'd6;
    endfunction

    function automatic logic [7:0] sr_byte(input status_t s);
        return {s.ready, 1'b0, s.ers_err, s.prg_err, s.vpp_low, 3'b000};
    endfunction

endpackage

// File: rtl/bbf_array.sv
module bbf_array
    import bbf_pkg::*;
#(
    parameter int UNIT_LOG2 = 2,
    parameter bit TOP_BOOT  = 1'b1,
    localparam int AW       = 6 + UNIT_LOG2,
    localparam int DEPTH    = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          apply,
    input  op_t           op,
    input  logic [AW-1:0] op_addr,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_word
);
    logic [15:0] mem [DEPTH];
    logic [2:0]  tgt_blk;

    assign tgt_blk = blk_of_unit(op_addr[AW-1 -: 6], TOP_BOOT);
    assign rd_word = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
        end else if (apply) begin
            if (op.erase) begin
                for (int i = 0; i < DEPTH; i++)
                    if (blk_of_unit(6'(i >> UNIT_LOG2), TOP_BOOT) == tgt_blk)
                        mem[i] <= 16'hFFFF;
            end else if (op.byte_wr) begin
                if (op.hi_byte) mem[op_addr][15:8] <= mem[op_addr][15:8] & op.data[7:0];
                else            mem[op_addr][7:0]  <= mem[op_addr][7:0]  & op.data[7:0];
            end else begin
                mem[op_addr] <= mem[op_addr] & op.data;
            end
        end
    end
endmodule

// File: rtl/bbf_cmd_fsm.sv
module bbf_cmd_fsm
    import bbf_pkg::*;
#(
    parameter int AW          = 8,
    parameter int BUSY_CYCLES = 16,
    parameter bit TOP_BOOT    = 1'b1,
    localparam int CW         = $clog2(BUSY_CYCLES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd,
    input  logic          wr_pulse,
    input  logic [15:0]   din,
    input  logic [AW-1:0] addr,
    input  logic          byte_n,
    input  logic          hv_ok,
    input  logic          unlock,
    output rd_mode_e      mode,
    output status_t       sts,
    output logic          apply,
    output op_t           op,
    output logic [AW-1:0] op_addr
);
    cel_state_e    state;
    logic [CW-1:0] cnt;
    logic          vfail, ers_err, prg_err, vpp_low;
    logic          is_boot, arm_erase;

    assign is_boot   = blk_of_unit(addr[AW-1 -: 6], TOP_BOOT) == 3'd0;
    assign arm_erase = (state == ST_ERS_ARM);
    assign sts = '{ready: (state != ST_BUSY), ers_err: ers_err, prg_err: prg_err, vpp_low: vpp_low};

    always_ff @(posedge clk) begin
        if (rst || pd) begin
            state   <= ST_IDLE;
            mode    <= RD_ARRAY;
            ers_err <= 1'b0;
            prg_err <= 1'b0;
            vpp_low <= 1'b0;
            vfail   <= 1'b0;
            cnt     <= '0;
            apply   <= 1'b0;
            op      <= '0;
            op_addr <= '0;
        end else begin
            apply <= 1'b0;
            case (state)
                ST_BUSY: begin
                    if (!hv_ok) vfail <= 1'b1;
                    if (cnt == '0) begin
                        state <= ST_IDLE;
                        if (vfail || !hv_ok) begin
                            vpp_low <= 1'b1;
                            if (op.erase) ers_err <= 1'b1;
                            else          prg_err <= 1'b1;
                        end else begin
                            apply <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_ERS_ARM, ST_PRG_ARM: if (wr_pulse) begin
                    mode  <= RD_STATUS;
                    state <= ST_IDLE;
                    if (arm_erase && din[7:0] != CMD_CONFIRM) begin
                        ers_err <= 1'b1;
                        prg_err <= 1'b1;
                    end else begin
                        op      <= '{erase: arm_erase, byte_wr: !byte_n, hi_byte: din[15], data: din};
                        op_addr <= addr;
                        if (!hv_ok) begin
                            vpp_low <= 1'b1;
                            if (arm_erase) ers_err <= 1'b1;
                            else           prg_err <= 1'b1;
                        end else if (is_boot && !unlock) begin
                            ers_err <= 1'b1;
                            prg_err <= 1'b1;
                        end else begin
                            state <= ST_BUSY;
                            cnt   <= CW'(BUSY_CYCLES - 1);
                            vfail <= 1'b0;
                        end
                    end
                end
                default: if (wr_pulse) begin
                    case (din[7:0])
                        CMD_READ_ARRAY:         mode  <= RD_ARRAY;
                        CMD_IDENT:              mode  <= RD_IDENT;
                        CMD_STATUS:             mode  <= RD_STATUS;
                        CMD_ERASE:              state <= ST_ERS_ARM;
                        CMD_PROG_A, CMD_PROG_B: state <= ST_PRG_ARM;
                        default: ;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/bbf_read_mux.sv
module bbf_read_mux
    import bbf_pkg::*;
#(
    parameter bit TOP_BOOT = 1'b1
) (
    input  rd_mode_e    mode,
    input  logic [15:0] word,
    input  logic        byte_n,
    input  logic        a_lo,
    input  logic        a0,
    input  status_t     sts,
    output logic [15:0] value
);
    logic [15:0] id_code;

    always_comb begin
        id_code = a0 ? (TOP_BOOT ? DEV_TOP : DEV_BOT) : MFR_CODE;
        case (mode)
            RD_IDENT:  value = byte_n ? id_code : {8'h00, id_code[7:0]};
            RD_STATUS: value = {8'h00, sr_byte(sts)};
            default:   value = byte_n ? word : {8'h00, (a_lo ? word[15:8] : word[7:0])};
        endcase
    end
endmodule

// File: rtl/bbf_cmd_ctrl.sv
module bbf_cmd_ctrl
    import bbf_pkg::*;
#(
    parameter int UNIT_LOG2   = 2,
    parameter int BUSY_CYCLES = 16,
    parameter bit TOP_BOOT    = 1'b1,
    localparam int AW         = 6 + UNIT_LOG2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pwr_down_n,
    input  logic          rst_hv_unlock,
    input  logic          boot_wp_release,
    input  logic          vpp_good,
    input  logic          chip_sel_n,
    input  logic          wr_strobe_n,
    input  logic          out_en_n,
    input  logic          byte_mode_n,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   dq_in,
    output logic [15:0]   dq_out,
    output logic [15:0]   dq_oe
);
    logic          s_pd_n, s_ce_n, s_we_n, s_we_d, s_oe_n, s_byte_n;
    logic          s_hv_ok, s_unlock;
    logic [AW-1:0] s_addr;
    logic [15:0]   s_din;
    logic          wr_pulse, apply;
    rd_mode_e      mode;
    status_t       sts;
    op_t           op;
    logic [AW-1:0] op_addr;
    logic [15:0]   rd_word, rd_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_pd_n   <= 1'b1;
            s_ce_n   <= 1'b1;
            s_we_n   <= 1'b1;
            s_we_d   <= 1'b1;
            s_oe_n   <= 1'b1;
            s_byte_n <= 1'b1;
            s_hv_ok  <= 1'b0;
            s_unlock <= 1'b0;
            s_addr   <= '0;
            s_din    <= '0;
        end else begin
            s_pd_n   <= pwr_down_n;
            s_ce_n   <= chip_sel_n;
            s_we_n   <= wr_strobe_n;
            s_we_d   <= s_we_n;
            s_oe_n   <= out_en_n;
            s_byte_n <= byte_mode_n;
            s_hv_ok  <= vpp_good;
            s_unlock <= boot_wp_release | rst_hv_unlock;
            s_addr   <= addr;
            s_din    <= dq_in;
        end
    end

    assign wr_pulse = s_pd_n & ~s_ce_n & s_we_n & ~s_we_d;

    bbf_cmd_fsm #(.AW(AW), .BUSY_CYCLES(BUSY_CYCLES), .TOP_BOOT(TOP_BOOT)) u_fsm (
        .clk(clk), .rst(rst), .pd(~s_pd_n), .wr_pulse(wr_pulse), .din(s_din),
        .addr(s_addr), .byte_n(s_byte_n), .hv_ok(s_hv_ok), .unlock(s_unlock),
        .mode(mode), .sts(sts), .apply(apply), .op(op), .op_addr(op_addr)
    );

    bbf_array #(.UNIT_LOG2(UNIT_LOG2), .TOP_BOOT(TOP_BOOT)) u_array (
        .clk(clk), .rst(rst), .apply(apply), .op(op), .op_addr(op_addr),
        .rd_addr(s_addr), .rd_word(rd_word)
    );

    bbf_read_mux #(.TOP_BOOT(TOP_BOOT)) u_rmux (
        .mode(mode), .word(rd_word), .byte_n(s_byte_n), .a_lo(s_din[15]),
        .a0(s_addr[0]), .sts(sts), .value(rd_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dq_out <= '0;
            dq_oe  <= '0;
        end else begin
            dq_out <= rd_val;
            if (!s_pd_n || s_ce_n || s_oe_n || !s_we_n) dq_oe <= '0;
            else dq_oe <= s_byte_n ? 16'hFFFF : 16'h00FF;
        end
    end
endmodule

// File: rtl/bbf_cmd_ctrl_chk.sv
module bbf_cmd_ctrl_chk
    import bbf_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        s_pd_n,
    input logic        s_hv_ok,
    input logic [15:0] dq_oe,
    input rd_mode_e    mode,
    input status_t     sts,
    input logic        apply
);
    // R8: power-down disables every output lane
    assert_pd_tristate_R8: assert property (@(posedge clk) disable iff (rst)
        !s_pd_n |=> dq_oe == 16'h0000);

    // R1: power-down clears error bits and returns to array reads
    assert_pd_clears_R1: assert property (@(posedge clk) disable iff (rst)
        !s_pd_n |=> (!sts.ers_err && !sts.prg_err && !sts.vpp_low && mode == RD_ARRAY));

    // R5: while busy, reads come from the status register
    assert_busy_status_R5: assert property (@(posedge clk) disable iff (rst)
        !sts.ready |-> mode == RD_STATUS);

    // R7: an operation only starts with a valid supply
    assert_start_hv_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(sts.ready) |-> $past(s_hv_ok));

    // R4: array update only at completion of a busy phase
    assert_apply_at_done_R4: assert property (@(posedge clk) disable iff (rst)
        apply |-> $rose(sts.ready));

    // R10: lane enables are either all, low byte, or none
    assert_lane_shape_R10: assert property (@(posedge clk) disable iff (rst)
        dq_oe == 16'h0000 || dq_oe == 16'h00FF || dq_oe == 16'hFFFF);
endmodule

bind bbf_cmd_ctrl bbf_cmd_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .s_pd_n(s_pd_n), .s_hv_ok(s_hv_ok), .dq_oe(dq_oe),
    .mode(mode), .sts(sts), .apply(apply)
);

// File: tb/tb_bbf_cmd_ctrl.sv
module tb_bbf_cmd_ctrl;
    localparam int BUSY = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_down_n = 1'b1, rst_hv_unlock = 1'b0, boot_wp_release = 1'b0, vpp_good = 1'b1;
    logic        chip_sel_n = 1'b1, wr_strobe_n = 1'b1, out_en_n = 1'b1, byte_mode_n = 1'b1;
    logic [7:0]  addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe;

    always #10 clk = ~clk;

    bbf_cmd_ctrl #(.UNIT_LOG2(2), .BUSY_CYCLES(BUSY), .TOP_BOOT(1'b1)) dut (
        .clk(clk), .rst(rst), .pwr_down_n(pwr_down_n), .rst_hv_unlock(rst_hv_unlock),
        .boot_wp_release(boot_wp_release), .vpp_good(vpp_good), .chip_sel_n(chip_sel_n),
        .wr_strobe_n(wr_strobe_n), .out_en_n(out_en_n), .byte_mode_n(byte_mode_n),
        .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    typedef struct {
        logic [15:0] d;
        logic [15:0] oe;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   vectors = 0, miscompares = 0;
    bit   done = 1'b0;
    event sample_ev;

    // monitor: compare each sampled output against the queue head
    initial forever begin
        @(sample_ev);
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            vectors++;
            if (dq_oe !== e.oe || ((dq_out & e.oe) !== (e.d & e.oe))) begin
                miscompares++;
                $display("FAIL %s: got d=%h oe=%h, expected d=%h oe=%h", e.tag, dq_out, dq_oe, e.d, e.oe);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        chip_sel_n = 1'b0; wr_strobe_n = 1'b0; addr = a; dq_in = d;
        cyc(2);
        wr_strobe_n = 1'b1;
        cyc(2);
        chip_sel_n = 1'b1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic alo, input logic [15:0] ed,
                          input logic [15:0] eoe, input string tag);
        @(negedge clk);
        chip_sel_n = 1'b0; out_en_n = 1'b0; addr = a; dq_in = {alo, 15'h0};
        cyc(4);
        exp_q.push_back('{d: ed, oe: eoe, tag: tag});
        -> sample_ev;
        cyc(1);
        out_en_n = 1'b1; chip_sel_n = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] ed, input string tag);
        rd_chk(a, 1'b0, ed, 16'hFFFF, tag);
    endtask

    task automatic pd_pulse();
        @(negedge clk); pwr_down_n = 1'b0;
        cyc(3);
        pwr_down_n = 1'b1;
        cyc(3);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        cyc(4); rst = 1'b0; cyc(3);

        // R1, R11: reset state is array read of erased cells
        rd(8'd0, 16'hFFFF, "R1 reset array read");
        // R12: no drive without out_en
        @(negedge clk); chip_sel_n = 1'b0; cyc(4);
        exp_q.push_back('{d: 16'h0, oe: 16'h0, tag: "R12 idle lanes off"}); -> sample_ev;
        cyc(1); chip_sel_n = 1'b1;

        // R9: identifier codes, word and byte mode
        wr(8'd0, 16'h0090);
        rd(8'd0, 16'h0089, "R9 mfr word");
        rd(8'd1, 16'h4470, "R9 dev word");
        byte_mode_n = 1'b0;
        rd_chk(8'd0, 1'b0, 16'h0089, 16'h00FF, "R9 R10 mfr byte");
        rd_chk(8'd1, 1'b0, 16'h0070, 16'h00FF, "R9 R10 dev byte");
        byte_mode_n = 1'b1;

        // R4, R5: program, busy status, stays in status mode
        wr(8'd0, 16'h0040);
        wr(8'd5, 16'h1234);
        rd(8'd5, 16'h0000, "R5 busy ready low");
        cyc(BUSY + 6);
        rd(8'd5, 16'h0080, "R5 status after program");
        wr(8'd0, 16'h00FF);
        rd(8'd5, 16'h1234, "R4 programmed word");
        wr(8'd0, 16'h0010);
        wr(8'd5, 16'hF0F0);
        cyc(BUSY + 6);
        wr(8'd0, 16'h00FF);
        rd(8'd5, 16'h1030, "R4 AND of old and new");

        // R10: byte reads and byte program
        byte_mode_n = 1'b0;
        rd_chk(8'd5, 1'b1, 16'h0010, 16'h00FF, "R10 upper byte");
        rd_chk(8'd5, 1'b0, 16'h0030, 16'h00FF, "R10 lower byte");
        wr(8'd0, 16'h0040);
        wr(8'd6, 16'h805A);
        cyc(BUSY + 6);
        wr(8'd0, 16'h00FF);
        byte_mode_n = 1'b1;
        rd(8'd6, 16'h5AFF, "R10 byte program upper only");

        // R3: bad confirm
        wr(8'd0, 16'h0020);
        wr(8'd10, 16'h0055);
        rd(8'd0, 16'h00B0, "R3 sequence error status");
        wr(8'd0, 16'h00FF);
        rd(8'd5, 16'h1030, "R3 no erase");

        // R8, R1: power-down
        @(negedge clk); pwr_down_n = 1'b0; cyc(2);
        rd_chk(8'd5, 1'b0, 16'h0, 16'h0, "R8 lanes off in power-down");
        wr(8'd0, 16'h0090);
        pwr_down_n = 1'b1; cyc(3);
        rd(8'd5, 16'h1030, "R8 R1 write ignored, array mode");
        wr(8'd0, 16'h0070);
        rd(8'd0, 16'h0080, "R1 errors cleared");

        // R2, R11: block erase
        wr(8'd0, 16'h0040);
        wr(8'd64, 16'hABCD);
        cyc(BUSY + 6);
        wr(8'd0, 16'h0020);
        wr(8'd10, 16'h00D0);
        cyc(BUSY + 6);
        wr(8'd0, 16'h00FF);
        rd(8'd5, 16'hFFFF, "R2 erased word 5");
        rd(8'd6, 16'hFFFF, "R2 erased word 6");
        rd(8'd64, 16'hABCD, "R2 R11 other block kept");

        // R6: boot protection paths
        wr(8'd0, 16'h0040);
        wr(8'd250, 16'h0F0F);
        cyc(BUSY + 6);
        rd(8'd0, 16'h00B0, "R6 refused status");
        wr(8'd0, 16'h00FF);
        rd(8'd250, 16'hFFFF, "R6 boot word unchanged");
        pd_pulse();
        boot_wp_release = 1'b1;
        wr(8'd0, 16'h0040);
        wr(8'd250, 16'h0F0F);
        cyc(BUSY + 6);
        wr(8'd0, 16'h00FF);
        rd(8'd250, 16'h0F0F, "R6 write-protect release path");
        boot_wp_release = 1'b0;
        rst_hv_unlock = 1'b1;
        wr(8'd0, 16'h0020);
        wr(8'd252, 16'h00D0);
        cyc(BUSY + 6);
        rd(8'd0, 16'h0080, "R6 super-voltage erase ok");
        wr(8'd0, 16'h00FF);
        rd(8'd250, 16'hFFFF, "R6 super-voltage path erased");
        rst_hv_unlock = 1'b0;
        wr(8'd0, 16'h0040);
        wr(8'd244, 16'h00FF);
        cyc(BUSY + 6);
        wr(8'd0, 16'h00FF);
        rd(8'd244, 16'h00FF, "R6 R11 parameter block ignores protection");

        // R7: supply low at confirm
        vpp_good = 1'b0;
        wr(8'd0, 16'h0040);
        wr(8'd7, 16'h0000);
        cyc(BUSY + 6);
        vpp_good = 1'b1;
        rd(8'd0, 16'h0098, "R7 low supply at confirm");
        wr(8'd0, 16'h00FF);
        rd(8'd7, 16'hFFFF, "R7 word untouched");
        pd_pulse();

        // R7: supply drop mid-operation
        wr(8'd0, 16'h0040);
        wr(8'd8, 16'h0000);
        cyc(3); vpp_good = 1'b0; cyc(2); vpp_good = 1'b1;
        cyc(BUSY + 6);
        rd(8'd0, 16'h0098, "R7 drop during busy");
        wr(8'd0, 16'h00FF);
        rd(8'd8, 16'hFFFF, "R7 word untouched after drop");

        cyc(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule